// File: doc/BRIEF.md
# Daisy-Chain DAC Command Master

This block is the host-side serial master for a string of serial DACs wired in a daisy chain. The devices share one serial clock and one active-low select/load line. The data output of each device feeds the data input of the next device. The host names one device, a 4-bit command and a 16-bit code, then pulses `start`. The block shifts out one 32-bit word per device, back to back, under a single low period of the select line. It then raises the select line so that every device executes its own word in the same instant.

The word for the addressed device carries the host command and code. Every other device receives the no-operation command, so it keeps its state. The first word shifted out passes through the whole chain and ends up in the farthest device, so the block sends the words farthest-device first. The serial clock runs at a rate divided down from the system clock. The host picks the half period in system cycles at each start.

The host side is a strobe interface. `busy` covers the transfer, and a one-cycle `done` pulse closes it. Read-back data from the chain is not received.

Top module: `dac_chain_master`

## Requirements
- R1: After reset `sel_n` is 1, and `sck`, `mosi`, `busy` and `done` are 0. Whenever `sel_n` is 1, `sck` is 0.
- R2: One transfer gives exactly 32*NUM_DEV rising edges of `sck`, all while `sel_n` is low. `sel_n` stays low from the first edge to the last edge without a break.
- R3: The word for the addressed device is 32 bits, sent MSB first. Bits 31:24 are 0, bits 23:20 are the command `op`, bits 19:16 are 0, and bits 15:0 are `value`.
- R4: Words go out in reverse device order. Device 0 sits next to the host. The first word sent goes to device NUM_DEV-1, and the last word sent goes to device 0.
- R5: Every device except the one named by `dev_sel` gets command 4'b1111. Its other 28 bits are 0.
- R6: `sck` idles low. In a transfer each high phase and each low phase lasts exactly H system cycles. H is the value of `half_div` captured at `start`, and a value of 0 counts as 1.
- R7: `mosi` changes only while `sck` is low, so it is stable over every high phase.
- R8: `sel_n` falls H cycles before the first rising edge of `sck`. It rises H cycles after the last falling edge of `sck`.
- R9: After `sel_n` rises it stays high for H cycles, and then `done` is high for one cycle. `busy` is high from the cycle after `start` is accepted until the cycle before `done`.
- R10: A `start` that arrives while `busy` is high is ignored. The frame in progress is unchanged, and no extra clock pulses or `done` pulses appear.
- R11: A `start` given in the same cycle as `done` is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one transfer (taken when idle) |
| dev_sel | input | IDX_W | Index of the addressed device, 0 = nearest to host |
| op | input | 4 | Command for the addressed device |
| value | input | 16 | Data code for the addressed device |
| half_div | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| sck | output | 1 | Serial clock to the chain |
| mosi | output | 1 | Serial data to the first device |
| sel_n | output | 1 | Active-low select/load shared by the chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
Two host-side events can fall in the same cycle: the `done` pulse of one transfer and the `start` of the next. The bench waits until it sees `done` high. In that same cycle it raises `start` with a new device, command and code. It then expects a complete second frame with the new contents and correct timing. A second case raises `start` in the middle of a running frame, with different contents. The bench judges that case by the captured frame, which must still match the first request, and by an edge count of exactly 32*NUM_DEV with a single `done` pulse.

// File: rtl/dac_chain_master.sv
module dac_chain_master #(
  parameter int NUM_DEV = 3,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] dev_sel,
  input  logic [3:0]       op,
  input  logic [15:0]      value,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             mosi,
  output logic             sel_n,
  output logic             busy,
  output logic             done
);
  localparam int BITS  = 32 * NUM_DEV;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [3:0] NOP = 4'hF;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_GAP} state_t;
  state_t state;

  logic [DIV_W-1:0] cnt, half_q, lim;
  logic [CNT_W-1:0] bit_cnt, hit_word, nxt, start_hw;
  logic [3:0]       op_q;
  logic [15:0]      val_q;
  logic             tick, last_bit;

  function automatic logic pick(input logic [CNT_W-1:0] b, input logic [CNT_W-1:0] hw,
                                input logic [3:0] o, input logic [15:0] v);
    logic [31:0] w;
    w = ((b >> 5) == hw) ? {8'h00, o, 4'h0, v} : {8'h00, NOP, 4'h0, 16'h0000};
    return w[~b[4:0]];
  endfunction

  assign lim      = (half_q == '0) ? DIV_W'(1) : half_q;
  assign tick     = (cnt == lim - DIV_W'(1));
  assign busy     = (state != S_IDLE);
  assign last_bit = (bit_cnt == CNT_W'(BITS - 1));
  assign nxt      = bit_cnt + CNT_W'(1);
  assign start_hw = CNT_W'(NUM_DEV - 1) - CNT_W'(dev_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      half_q   <= '0;
      bit_cnt  <= '0;
      hit_word <= '0;
      op_q     <= '0;
      val_q    <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      sel_n    <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) cnt <= '0;
      else                 cnt <= tick ? '0 : cnt + DIV_W'(1);
      case (state)
        S_IDLE: if (start) begin
          half_q   <= half_div;
          hit_word <= start_hw;
          op_q     <= op;
          val_q    <= value;
          bit_cnt  <= '0;
          mosi     <= pick('0, start_hw, op, value);
          sel_n    <= 1'b0;
          state    <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          sck   <= 1'b1;
          state <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (sck) begin
            sck <= 1'b0;
            if (last_bit) state <= S_TAIL;
            else begin
              bit_cnt <= nxt;
              mosi    <= pick(nxt, hit_word, op_q, val_q);
            end
          end else begin
            sck <= 1'b1;
          end
        end
        S_TAIL: if (tick) begin
          sel_n <= 1'b1;
          mosi  <= 1'b0;
          state <= S_GAP;
        end
        S_GAP: if (tick) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dac_chain_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sck,
  input logic mosi,
  input logic sel_n,
  input logic busy,
  input logic done
);
  assert_clk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !sck);
  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_sel_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (!sck && !$past(sck)));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && sel_n));
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !sel_n));
  assert_sel_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> busy);
endmodule

bind dac_chain_master dac_chain_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sck(sck), .mosi(mosi),
  .sel_n(sel_n), .busy(busy), .done(done)
);

// File: tb/tb_dac_chain_master.sv
module tb_dac_chain_master;
  localparam int N     = 3;
  localparam int DIV_W = 8;
  localparam int IDX_W = 2;
  localparam int BITS  = 32 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] dev_sel = '0;
  logic [3:0] op = '0;
  logic [15:0] value = '0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic sck, mosi, sel_n, busy, done;

  dac_chain_master #(.NUM_DEV(N), .DIV_W(DIV_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel), .op(op),
    .value(value), .half_div(half_div), .sck(sck), .mosi(mosi),
    .sel_n(sel_n), .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic cap [0:BITS-1];
  int rises, lo_run, hi_run, lo_min, lo_max, hi_min, hi_max;
  int tail_len, gap_run, done_cnt, mosi_bad, sel_break, busy_bad;
  logic p_sck = 1'b0, p_mosi = 1'b0, p_sel = 1'b1, seen_rise = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; lo_run = 0; hi_run = 0; lo_min = 1 << 20; lo_max = 0;
    hi_min = 1 << 20; hi_max = 0; tail_len = -1; gap_run = 0; done_cnt = 0;
    mosi_bad = 0; sel_break = 0; busy_bad = 0; seen_rise = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sel_n) begin
        if (!busy) busy_bad++;
        if (sck) begin
          if (!p_sck) begin
            if (rises < BITS) cap[rises] = mosi;
            rises++;
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
            lo_run = 0;
            seen_rise = 1'b1;
          end else if (mosi != p_mosi) mosi_bad++;
          hi_run++;
        end else begin
          if (p_sck) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
          end
          lo_run++;
        end
      end else begin
        if (!p_sel && seen_rise) tail_len = lo_run;
        if (!p_sel && rises > 0 && rises < BITS) sel_break++;
        if (busy) gap_run++;
      end
      if (done) done_cnt++;
    end
    p_sck = sck; p_mosi = mosi; p_sel = sel_n;
  end

  function automatic logic [31:0] exp_word(input int w, input int idx,
                                           input logic [3:0] o, input logic [15:0] v);
    int dev = N - 1 - w;
    return (dev == idx) ? {8'h00, o, 4'h0, v} : {8'h00, 4'hF, 4'h0, 16'h0000};
  endfunction

  task automatic launch(input int idx, input logic [3:0] o, input logic [15:0] v,
                        input int h);
    @(negedge clk); #1;
    clear_mon();
    dev_sel = IDX_W'(idx); op = o; value = v; half_div = DIV_W'(h); start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      if (done) break;
    end
  endtask

  task automatic check_frame(input int idx, input logic [3:0] o, input logic [15:0] v,
                             input int h, input string tag);
    int he = (h == 0) ? 1 : h;
    chk(done == 1'b1, {tag, " R9 done reached"}, done, 1);
    chk(rises == BITS, {tag, " R2 clock pulse count"}, rises, BITS);
    chk(sel_break == 0, {tag, " R2 select unbroken"}, sel_break, 0);
    for (int w = 0; w < N; w++) begin
      logic [31:0] got, want;
      want = exp_word(w, idx, o, v);
      for (int j = 0; j < 32; j++) got[31-j] = cap[w*32+j];
      if (N - 1 - w == idx) chk(got == want, {tag, " R3 R4 addressed word"}, got, want);
      else                  chk(got == want, {tag, " R5 no-op word"}, got, want);
    end
    chk(hi_min == he && hi_max == he, {tag, " R6 high phase"}, hi_max, he);
    chk(lo_min == he && lo_max == he, {tag, " R6 R8 low phase and lead"}, lo_max, he);
    chk(tail_len == he, {tag, " R8 select tail"}, tail_len, he);
    chk(gap_run == he, {tag, " R9 select high gap"}, gap_run, he);
    chk(mosi_bad == 0, {tag, " R7 data stable while clock high"}, mosi_bad, 0);
    chk(busy_bad == 0, {tag, " R9 busy over transfer"}, busy_bad, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(sel_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R1 reset lines", {sel_n, sck, mosi}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset status", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic test_basic(input int idx, input logic [3:0] o, input logic [15:0] v,
                            input int h, input string tag);
    launch(idx, o, v, h);
    chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
    wait_done();
    check_frame(idx, o, v, h, tag);
    repeat (3) @(negedge clk);
    #1;
    chk(done_cnt == 1, {tag, " R9 single done pulse"}, done_cnt, 1);
    chk(sel_n && !sck, {tag, " R1 idle after transfer"}, {sel_n, sck}, 2'b10);
  endtask

  task automatic test_ignore_start();
    launch(1, 4'h3, 16'hBEEF, 2);
    repeat (40) @(negedge clk);
    #1;
    dev_sel = 2'd0; op = 4'h4; value = 16'h1234; half_div = 8'd1; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    wait_done();
    check_frame(1, 4'h3, 16'hBEEF, 2, "R10");
    repeat (3) @(negedge clk);
    #1;
    chk(done_cnt == 1, "R10 no extra done", done_cnt, 1);
  endtask

  task automatic test_start_on_done();
    launch(0, 4'h0, 16'h0F0F, 1);
    wait_done();
    clear_mon();
    dev_sel = 2'd2; op = 4'h1; value = 16'hA55A; half_div = 8'd2; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R11 start in done cycle accepted", busy, 1);
    wait_done();
    check_frame(2, 4'h1, 16'hA55A, 2, "R11");
  endtask

  initial begin
    clear_mon();
    test_reset();
    test_basic(0, 4'h3, 16'h8001, 1, "T0");
    test_basic(2, 4'h0, 16'hFFFF, 3, "T2");
    test_basic(1, 4'h4, 16'h0000, 0, "T1");
    test_ignore_start();
    test_start_on_done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule